// File: doc/BRIEF.md
# Indirect Pointer Address Translator

This block turns a 16-bit indirect pointer into a physical access for a banked microcontroller core. A pointer can land in one of three places: the classic banked data space, a linear window that joins the general-purpose RAM chunks of successive banks into one gap-free array, or program memory. For data accesses the block drives a bank number and an in-bank offset straight onto a synchronous data RAM port in the same cycle as the request. For program-memory reads it registers the word address, requests one extra cycle from the core through a stall output, and returns the low byte of the addressed word.

Read data comes back one cycle after the request for data memory and for unmapped addresses, and two cycles after the request for program memory. Pointer arithmetic stays in the core. The RAM and flash arrays sit outside the block. The flash port carries only the low byte lane of each word.

Top module: `ptr_xlate`

## Requirements
- R1: A pointer in 0x0000–0x0FFF drives `ram_en` high in the request cycle, with `ram_bank` = pointer bits 11:7 and `ram_off` = pointer bits 6:0, unless R2 applies.
- R2: A banked pointer whose offset is 0x00–0x0B (core registers) or 0x70–0x7F (common memory) drives `ram_bank` = 0 whatever its bank bits, so all banks alias one physical location.
- R3: A pointer 0x2000 + n with n < GPR_BANKS*80 drives `ram_bank` = n/80 and `ram_off` = 0x20 + (n mod 80), so linear and banked views of the same RAM byte share data.
- R4: Pointers in 0x1000–0x1FFF, 0x2A00–0x7FFF, and linear indexes n >= GPR_BANKS*80 up to 0x29FF access neither array. A read there returns `rd_valid` with `rdata` = 0 one cycle later, and a write there changes nothing.
- R5: A read of a pointer with bit 15 set raises `stall`, `rom_en` and `rom_addr` = pointer bits 14:0 in the following cycle. In the cycle after that it gives `rd_valid` with `rdata` equal to the flash low byte.
- R6: A write with pointer bit 15 set drives neither array, raises no `stall` and produces no `rd_valid`.
- R7: A data RAM read gives `rd_valid` one cycle after the request, with `rdata` equal to the RAM output byte.
- R8: A request presented while `stall` is high is dropped. It drives no array and produces no later `rd_valid`.
- R9: While and after synchronous reset, `rd_valid`, `stall` and `rom_en` are low and `rdata` is 0.
- R10: A data RAM write drives `ram_we` high with `ram_wdata` = `wdata` and produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| ptr | input | 16 | Indirect pointer value |
| wdata | input | 8 | Write byte |
| stall | output | 1 | Extra cycle request during a program-memory read |
| rd_valid | output | 1 | Read result present on `rdata` |
| rdata | output | 8 | Read result byte |
| ram_en | output | 1 | Data RAM access enable |
| ram_we | output | 1 | Data RAM write enable |
| ram_bank | output | 5 | Data RAM bank |
| ram_off | output | 7 | Data RAM offset within bank |
| ram_wdata | output | 8 | Data RAM write byte |
| ram_rdata | input | 8 | Data RAM read byte, valid the cycle after `ram_en` |
| rom_en | output | 1 | Flash read enable |
| rom_addr | output | 15 | Flash word address |
| rom_rdata | input | 8 | Flash low byte lane, valid the cycle after `rom_en` |

## Verification
The hardest situation to reach from the ports is a request that arrives in the single stall cycle of a program-memory read. It has to be dropped without disturbing the pending flash result. A directed sequence places a data read exactly in that cycle and then watches the next two cycles for the flash byte and for the absence of a second result. The other hard case is the aliasing of linear, banked and shared addresses. The bench writes through one view and reads back through another, at the chunk seams and at the last implemented linear byte. Random pointers spread over all regions fill the rest.

// File: rtl/ptr_xlate_pkg.sv
`timescale 1ns/1ps
package ptr_xlate_pkg;
    localparam int PTR_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int BANK_W  = 5;
    localparam int OFF_W   = 7;
    localparam int PADDR_W = PTR_W - 1;
    localparam int LIN_W   = 12;

    localparam int          GPR_LEN    = 80;
    localparam logic [6:0]  GPR_BASE   = 7'h20;
    localparam logic [6:0]  CORE_LAST  = 7'h0B;
    localparam logic [6:0]  COMMON_LO  = 7'h70;
    localparam logic [11:0] LIN_LAST   = 12'h9FF;
    localparam logic [3:0]  NIB_BANKED = 4'h0;
    localparam logic [3:0]  NIB_LINEAR = 4'h2;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_RAM  = 2'd1,
        RG_ZERO = 2'd2,
        RG_PROG = 2'd3
    } region_e;

    typedef struct packed {
        region_e              region;
        logic [BANK_W-1:0]    bank;
        logic [OFF_W-1:0]     off;
        logic [PADDR_W-1:0]   paddr;
    } xlate_t;

    function automatic logic is_shared(input logic [OFF_W-1:0] off);
        return (off <= CORE_LAST) || (off >= COMMON_LO);
    endfunction
endpackage

// File: rtl/lin_map.sv
`timescale 1ns/1ps
module lin_map
    import ptr_xlate_pkg::*;
#(
    parameter int GPR_BANKS = 8,
    parameter int NSLOT     = 32
) (
    input  logic [LIN_W-1:0]  idx,
    output logic [BANK_W-1:0] bank,
    output logic [OFF_W-1:0]  off,
    output logic              hit
);
    localparam logic [LIN_W-1:0] LIN_SIZE = LIN_W'(GPR_BANKS * GPR_LEN);

    logic [NSLOT-1:0] ge;
    logic [LIN_W-1:0] base;

    // one threshold comparator per chunk start replaces a divider
    genvar g;
    generate
        for (g = 0; g < NSLOT; g++) begin : g_thr
            assign ge[g] = (idx >= LIN_W'(g * GPR_LEN));
        end
    endgenerate

    always_comb begin
        bank = '0;
        base = '0;
        for (int b = 0; b < NSLOT; b++) begin
            if (ge[b]) begin
                bank = BANK_W'(b);
                base = LIN_W'(b * GPR_LEN);
            end
        end
        off = GPR_BASE + OFF_W'(idx - base);
        hit = (idx < LIN_SIZE);
    end
endmodule

// File: rtl/region_dec.sv
`timescale 1ns/1ps
module region_dec
    import ptr_xlate_pkg::*;
#(
    parameter int GPR_BANKS = 8
) (
    input  logic [PTR_W-1:0] ptr,
    output xlate_t           xl
);
    logic [BANK_W-1:0] lin_bank;
    logic [OFF_W-1:0]  lin_off;
    logic              lin_hit;

    lin_map #(.GPR_BANKS(GPR_BANKS), .NSLOT(1 << BANK_W)) i_lin (
        .idx  (ptr[LIN_W-1:0]),
        .bank (lin_bank),
        .off  (lin_off),
        .hit  (lin_hit)
    );

    always_comb begin
        xl        = '0;
        xl.region = RG_ZERO;
        xl.paddr  = ptr[PADDR_W-1:0];
        if (ptr[PTR_W-1]) begin
            xl.region = RG_PROG;
        end else if (ptr[PTR_W-2:LIN_W] == NIB_BANKED[2:0]) begin
            xl.region = RG_RAM;
            xl.off    = ptr[OFF_W-1:0];
            xl.bank   = is_shared(ptr[OFF_W-1:0]) ? '0 : ptr[LIN_W-1:OFF_W];
        end else if ((ptr[PTR_W-2:LIN_W] == NIB_LINEAR[2:0]) &&
                     (ptr[LIN_W-1:0] <= LIN_LAST) && lin_hit) begin
            xl.region = RG_RAM;
            xl.bank   = lin_bank;
            xl.off    = lin_off;
        end
    end
endmodule

// File: rtl/rd_pipe.sv
`timescale 1ns/1ps
module rd_pipe
    import ptr_xlate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic               is_write,
    input  region_e            region,
    input  logic [PADDR_W-1:0] paddr,
    input  logic [BYTE_W-1:0]  ram_rdata,
    input  logic [BYTE_W-1:0]  rom_rdata,
    output logic               rom_en,
    output logic [PADDR_W-1:0] rom_addr,
    output logic               stall,
    output logic               rd_valid,
    output logic [BYTE_W-1:0]  rdata
);
    logic               pend_q;
    logic [PADDR_W-1:0] addr_q;
    region_e            sel_q;
    logic               rd_acc;

    assign rd_acc = accept && !is_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            addr_q <= '0;
            sel_q  <= RG_NONE;
        end else begin
            pend_q <= rd_acc && (region == RG_PROG);
            if (rd_acc && (region == RG_PROG))
                addr_q <= paddr;
            if (pend_q)
                sel_q <= RG_PROG;
            else if (rd_acc && (region != RG_PROG))
                sel_q <= region;
            else
                sel_q <= RG_NONE;
        end
    end

    assign rom_en   = pend_q;
    assign rom_addr = addr_q;
    assign stall    = pend_q;
    assign rd_valid = (sel_q != RG_NONE);

    always_comb begin
        unique case (sel_q)
            RG_RAM:  rdata = ram_rdata;
            RG_PROG: rdata = rom_rdata;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/ptr_xlate.sv
`timescale 1ns/1ps
module ptr_xlate
    import ptr_xlate_pkg::*;
#(
    parameter int GPR_BANKS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [15:0]        ptr,
    input  logic [7:0]         wdata,
    output logic               stall,
    output logic               rd_valid,
    output logic [7:0]         rdata,
    output logic               ram_en,
    output logic               ram_we,
    output logic [4:0]         ram_bank,
    output logic [6:0]         ram_off,
    output logic [7:0]         ram_wdata,
    input  logic [7:0]         ram_rdata,
    output logic               rom_en,
    output logic [14:0]        rom_addr,
    input  logic [7:0]         rom_rdata
);
    xlate_t xl;
    logic   accept;

    region_dec #(.GPR_BANKS(GPR_BANKS)) i_dec (
        .ptr (ptr),
        .xl  (xl)
    );

    assign accept    = req_valid && !stall;
    assign ram_en    = accept && (xl.region == RG_RAM);
    assign ram_we    = ram_en && req_write;
    assign ram_bank  = xl.bank;
    assign ram_off   = xl.off;
    assign ram_wdata = wdata;

    rd_pipe i_pipe (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .is_write  (req_write),
        .region    (xl.region),
        .paddr     (xl.paddr),
        .ram_rdata (ram_rdata),
        .rom_rdata (rom_rdata),
        .rom_en    (rom_en),
        .rom_addr  (rom_addr),
        .stall     (stall),
        .rd_valid  (rd_valid),
        .rdata     (rdata)
    );
endmodule

// File: rtl/ptr_xlate_chk.sv
`timescale 1ns/1ps
module ptr_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [15:0] ptr,
    input logic [7:0]  wdata,
    input logic        stall,
    input logic        rd_valid,
    input logic [7:0]  rdata,
    input logic        ram_en,
    input logic        ram_we,
    input logic [4:0]  ram_bank,
    input logic [6:0]  ram_off,
    input logic [7:0]  ram_wdata,
    input logic [7:0]  ram_rdata,
    input logic        rom_en,
    input logic [14:0] rom_addr,
    input logic [7:0]  rom_rdata
);
    p_prog_read_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && ptr[15] && !stall)
        |=> (stall && rom_en && (rom_addr == $past(ptr[14:0]))));

    p_result_after_stall_r5: assert property (@(posedge clk) disable iff (rst)
        stall |=> (rd_valid && !stall));

    p_no_ram_in_stall_r8: assert property (@(posedge clk) disable iff (rst)
        stall |-> !ram_en);

    p_shared_bank0_r2: assert property (@(posedge clk) disable iff (rst)
        (ram_en && ((ram_off <= 7'h0B) || (ram_off >= 7'h70))) |-> (ram_bank == 5'd0));

    p_linear_in_gpr_r3: assert property (@(posedge clk) disable iff (rst)
        (ram_en && (ptr[15:12] == 4'h2)) |-> ((ram_off >= 7'h20) && (ram_off <= 7'h6F)));

    p_ram_read_valid_r7: assert property (@(posedge clk) disable iff (rst)
        (ram_en && !ram_we) |=> rd_valid);

    p_prog_write_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && ptr[15]) |-> (!ram_en && !rom_en));

    p_write_no_result_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !stall) |=> !rd_valid);

    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> (!rd_valid && !stall && !rom_en));
endmodule

bind ptr_xlate ptr_xlate_chk i_chk (.*);

// File: tb/test_ptr_xlate.sv
`timescale 1ns/1ps
module test_ptr_xlate;
    localparam int GPR_BANKS = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [15:0] ptr;
    logic [7:0]  wdata;
    logic        stall, rd_valid, ram_en, ram_we, rom_en;
    logic [7:0]  rdata, ram_wdata, ram_rdata, rom_rdata;
    logic [4:0]  ram_bank;
    logic [6:0]  ram_off;
    logic [14:0] rom_addr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] mem [0:4095];
    logic [7:0] exp_mem [0:4095];

    always #2.5 clk = ~clk;

    ptr_xlate #(.GPR_BANKS(GPR_BANKS)) i_ptr_xlate (.*);

    function automatic logic [7:0] rom_lo(input logic [14:0] a);
        return 8'((32'(a) * 13 + 5) ^ (32'(a) >> 7));
    endfunction

    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[{ram_bank, ram_off}] <= ram_wdata;
            else        ram_rdata <= mem[{ram_bank, ram_off}];
        end
        if (rom_en) rom_rdata <= rom_lo(rom_addr);
    end

    // kind: 1 = data RAM, 2 = unmapped, 3 = program memory
    function automatic void exp_map(input logic [15:0] p, output int kind,
                                    output int b, output int o, output string tag);
        int n;
        b = 0; o = 0;
        if (p >= 16'h8000) begin
            kind = 3; tag = "R5";
        end else if (p < 16'h1000) begin
            kind = 1;
            b = int'(p) / 128;
            o = int'(p) % 128;
            if (o < 12 || o >= 112) begin b = 0; tag = "R2"; end
            else tag = "R1";
        end else if (p >= 16'h2000 && p <= 16'h29FF) begin
            n = int'(p) - 'h2000;
            if (n < GPR_BANKS * 80) begin
                kind = 1; b = n / 80; o = 32 + n % 80; tag = "R3";
            end else begin
                kind = 2; tag = "R4";
            end
        end else begin
            kind = 2; tag = "R4";
        end
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic op(input bit w, input logic [15:0] p, input logic [7:0] d);
        int kind, b, o;
        string tag;
        exp_map(p, kind, b, o, tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; ptr = p; wdata = d;
        #1;
        if (w && kind == 3) tag = "R6";
        chk(ram_en == (kind == 1), tag, int'(ram_en), int'(kind == 1));
        if (kind == 1) begin
            chk(ram_bank == 5'(b), tag, int'(ram_bank), b);
            chk(ram_off == 7'(o), tag, int'(ram_off), o);
            chk(ram_we == w, "R10", int'(ram_we), int'(w));
            if (w) begin
                chk(ram_wdata == d, "R10", int'(ram_wdata), int'(d));
                exp_mem[b * 128 + o] = d;
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        if (!w && kind == 3) begin
            chk(stall && rom_en, "R5", int'(stall), 1);
            chk(rom_addr == p[14:0], "R5", int'(rom_addr), int'(p[14:0]));
            chk(!rd_valid, "R5", int'(rd_valid), 0);
            @(negedge clk); #1;
            chk(rd_valid, "R5", int'(rd_valid), 1);
            chk(rdata == rom_lo(p[14:0]), "R5", int'(rdata), int'(rom_lo(p[14:0])));
        end else if (!w) begin
            chk(rd_valid, kind == 1 ? "R7" : "R4", int'(rd_valid), 1);
            chk(rdata == (kind == 1 ? exp_mem[b * 128 + o] : 8'h00),
                kind == 1 ? "R7" : "R4", int'(rdata),
                kind == 1 ? int'(exp_mem[b * 128 + o]) : 0);
        end else begin
            chk(!rd_valid && !stall, kind == 3 ? "R6" : "R10", int'(rd_valid), 0);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog R5 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] rp;
        void'($urandom(32'd4242));
        for (int i = 0; i < 4096; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
        ram_rdata = 8'h00; rom_rdata = 8'h00;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; ptr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        #1;
        // R9: reset state
        chk(!rd_valid && !stall && !rom_en, "R9", int'(rd_valid), 0);
        chk(rdata == 8'h00, "R9", int'(rdata), 0);
        @(negedge clk); rst = 1'b0;

        // R3 with alias back through banked view (bank 1, offset 0x20)
        op(1'b1, 16'h2050, 8'h5A);
        op(1'b0, 16'h00A0, 8'h00);
        // R3 last implemented linear byte, then first unmapped one (R4)
        op(1'b1, 16'h227F, 8'hC3);
        op(1'b0, 16'h03EF, 8'h00);
        op(1'b1, 16'h2280, 8'h77);
        op(1'b0, 16'h2280, 8'h00);
        op(1'b0, 16'h29FF, 8'h00);
        // R2: core register and common memory aliasing across banks
        op(1'b1, 16'h0005, 8'h11);
        op(1'b0, 16'h0F85, 8'h00);
        op(1'b1, 16'h0FFF, 8'h22);
        op(1'b0, 16'h007F, 8'h00);
        // R1: bank-specific area
        op(1'b1, 16'h0F8C, 8'h33);
        op(1'b0, 16'h0F8C, 8'h00);
        op(1'b0, 16'h000C, 8'h00);
        // R4 holes
        op(1'b1, 16'h1000, 8'h44);
        op(1'b0, 16'h1FFF, 8'h00);
        op(1'b0, 16'h2A00, 8'h00);
        op(1'b0, 16'h7FFF, 8'h00);
        // R5 / R6 program memory
        op(1'b0, 16'h8000, 8'h00);
        op(1'b0, 16'hFFFF, 8'h00);
        op(1'b1, 16'h8123, 8'h99);

        // R8: request arriving in the stall cycle is dropped
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; ptr = 16'h8456;
        @(negedge clk);
        ptr = 16'h00A0;
        #1;
        chk(stall && !ram_en, "R8", int'(ram_en), 0);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(rd_valid && rdata == rom_lo(15'h0456), "R8", int'(rdata), int'(rom_lo(15'h0456)));
        @(negedge clk); #1;
        chk(!rd_valid, "R8", int'(rd_valid), 0);

        // random mix across regions
        for (int i = 0; i < 400; i++) begin
            case ($urandom % 4)
                0: rp = 16'($urandom % 4096);
                1: rp = 16'h2000 + 16'($urandom % 2560);
                2: rp = 16'h8000 | 16'($urandom);
                default: rp = 16'($urandom);
            endcase
            op(1'($urandom), rp, 8'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule